// File: doc/BRIEF.md
# Low-Power Tamper Input Debouncer

This block filters two active-low wake-up or tamper pins. A pin counts only when a slow reference tick is present, so the length of the debounce window is measured in periods of that reference clock and not in fast clock cycles. One shared 3-bit length code sets the window for both pins, and the same code can switch the filtering off. A per-pin enable decides whether each pin takes part.

When an enabled pin stays low for long enough, the block gives a one-cycle wake-up request. If the clear option is set, the same event also gives a one-cycle strobe that wipes the lower half of a backup register bank. Each pin also sets a sticky status bit of its own, and software clears these bits with a read strobe.

The pins are taken to be already synchronous to the reference domain. That domain is carried in the fast clock as a one-cycle `refTick` enable.

Top module: `tamper_debounce`

## Requirements
- R1: A length code of 0 disables both pins: no wake-up, clear strobe or status bit results, whatever the pin levels are.
- R2: A code k from 1 to 7 needs the pin to be sampled low on k+1 consecutive reference ticks. The event is taken on that tick, and its outputs appear in the clock cycle after that tick's edge.
- R3: Pins are sampled only on cycles where `refTick` is 1. A low level between ticks neither advances nor resets a count.
- R4: A tick that samples the pin high before the count is complete restarts that pin's count from zero.
- R5: An event fires once for each low period. A pin that stays low after firing gives no further event until a tick has sampled it high.
- R6: A pin whose enable bit (bit i of `pinEn` for pin i) is 0 never produces an event and never sets its status bit.
- R7: `wakeReq` is a single-cycle pulse for each tick on which at least one pin fires.
- R8: `backupClr` pulses in the same cycle as `wakeReq` only when `clrEn` was 1 on the event tick. Otherwise it stays 0.
- R9: Status bit i (`statusFlags[i]`) is set by an event on pin i and then holds until it is read.
- R10: `statusRd` clears all status bits at the next edge. An event on that same edge wins, and its bit reads 1.
- R11: After reset, all outputs are 0 and all counts are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refTick | input | 1 | One-cycle pulse marking each reference clock period |
| pinN | input | 2 | Wake/tamper pins, active low, bit i = pin i |
| pinEn | input | 2 | Per-pin enable, bit i = pin i |
| dbcCode | input | 3 | Debounce length code, 0 = off, k = k+1 ticks |
| clrEn | input | 1 | Request a backup clear on each event |
| statusRd | input | 1 | Status read strobe, clears the sticky bits |
| wakeReq | output | 1 | Wake-up request pulse |
| backupClr | output | 1 | Backup bank lower-half clear pulse |
| statusFlags | output | 2 | Sticky per-pin event bits |

## Verification
The bench checks the firing tick for the shortest, the longest and a middle length code. A counter that is off by one would fire one tick early or one tick late. It holds a pin low across many cycles with no tick, to catch a design that counts fast clock cycles. It also lets a pin bounce high in the middle of a window, where a count that is not restarted would fire early. It keeps a pin low after firing, where a design with no re-arm rule would repeat its pulses. Finally it issues a status read on the same edge as an event, where the wrong priority would lose the flag.

// File: rtl/tamper_dbc_pkg.sv
package tamper_dbc_pkg;
  localparam int DBC_PINS   = 2;
  localparam int DBC_CODE_W = 3;
  // largest window is 2**CODE_W ticks, which needs one extra bit
  localparam int DBC_CNT_W  = DBC_CODE_W + 1;

  typedef struct packed {
    logic                 sample;     // reference tick: pins are evaluated
    logic                 enableAll;  // length code is non-zero
    logic [DBC_CNT_W-1:0] target;     // ticks needed for an event
  } dbcStrobe_t;
endpackage

// File: rtl/tamper_dbc_count.sv
module tamper_dbc_count
  import tamper_dbc_pkg::*;
#(
  parameter int NUM_PINS = DBC_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  dbcStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] pinN,
  input  logic [NUM_PINS-1:0] pinEn,
  output logic [NUM_PINS-1:0] hit
);
  localparam int CNT_W = DBC_CNT_W;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nextCnt;
    logic             fired;
    logic             live;

    assign live    = strobe.enableAll & pinEn[g];
    assign nextCnt = cnt + CNT_W'(1);
    // >= keeps a shortened window working when the code drops mid-count
    assign hit[g]  = strobe.sample & live & ~pinN[g] & ~fired &
                     (nextCnt >= strobe.target);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (!live) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (strobe.sample) begin
        if (pinN[g]) begin
          cnt   <= '0;
          fired <= 1'b0;
        end else if (!fired) begin
          if (hit[g]) begin
            cnt   <= '0;
            fired <= 1'b1;
          end else begin
            cnt <= nextCnt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tamper_dbc_ctrl.sv
module tamper_dbc_ctrl
  import tamper_dbc_pkg::*;
#(
  parameter int NUM_PINS = DBC_PINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  refTick,
  input  logic [DBC_CODE_W-1:0] dbcCode,
  input  logic                  clrEn,
  input  logic                  statusRd,
  input  logic [NUM_PINS-1:0]   hit,
  output dbcStrobe_t            strobe,
  output logic                  wakeReq,
  output logic                  backupClr,
  output logic [NUM_PINS-1:0]   statusFlags
);
  always_comb begin
    strobe.sample    = refTick;
    strobe.enableAll = (dbcCode != '0);
    strobe.target    = {1'b0, dbcCode} + DBC_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeReq     <= 1'b0;
      backupClr   <= 1'b0;
      statusFlags <= '0;
    end else begin
      wakeReq     <= |hit;
      backupClr   <= (|hit) & clrEn;
      statusFlags <= (statusRd ? '0 : statusFlags) | hit;
    end
  end
endmodule

// File: rtl/tamper_debounce.sv
module tamper_debounce
  import tamper_dbc_pkg::*;
#(
  parameter int NUM_PINS = DBC_PINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  refTick,
  input  logic [NUM_PINS-1:0]   pinN,
  input  logic [NUM_PINS-1:0]   pinEn,
  input  logic [DBC_CODE_W-1:0] dbcCode,
  input  logic                  clrEn,
  input  logic                  statusRd,
  output logic                  wakeReq,
  output logic                  backupClr,
  output logic [NUM_PINS-1:0]   statusFlags
);
  dbcStrobe_t          strobe;
  logic [NUM_PINS-1:0] hit;

  tamper_dbc_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .dbcCode(dbcCode),
    .clrEn(clrEn), .statusRd(statusRd), .hit(hit), .strobe(strobe),
    .wakeReq(wakeReq), .backupClr(backupClr), .statusFlags(statusFlags)
  );

  tamper_dbc_count #(.NUM_PINS(NUM_PINS)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pinN(pinN),
    .pinEn(pinEn), .hit(hit)
  );
endmodule

// File: rtl/tamper_debounce_chk.sv
module tamper_debounce_chk
  import tamper_dbc_pkg::*;
#(
  parameter int NUM_PINS = DBC_PINS
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  refTick,
  input logic [NUM_PINS-1:0]   pinEn,
  input logic [DBC_CODE_W-1:0] dbcCode,
  input logic                  clrEn,
  input logic                  statusRd,
  input logic                  wakeReq,
  input logic                  backupClr,
  input logic [NUM_PINS-1:0]   statusFlags
);
  p_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dbcCode) == '0) |-> !wakeReq);

  p_tick_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(refTick));

  p_clr_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    backupClr |-> ($past(clrEn) && wakeReq));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (statusFlags != '0));

  p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusRd) && !wakeReq) |-> (statusFlags == '0));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_en
    p_pin_en_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusFlags[g]) |-> $past(pinEn[g]));
  end
endmodule

bind tamper_debounce tamper_debounce_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rstN(rstN), .refTick(refTick), .pinEn(pinEn),
  .dbcCode(dbcCode), .clrEn(clrEn), .statusRd(statusRd),
  .wakeReq(wakeReq), .backupClr(backupClr), .statusFlags(statusFlags)
);

// File: tb/tamper_debounce_tb.sv
module tamper_debounce_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic [1:0] pinN = 2'b11;
  logic [1:0] pinEn = 2'b00;
  logic [2:0] dbcCode = 3'd0;
  logic       clrEn = 1'b0;
  logic       statusRd = 1'b0;
  logic       wakeReq, backupClr;
  logic [1:0] statusFlags;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tamper_debounce u_dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .pinN(pinN), .pinEn(pinEn),
    .dbcCode(dbcCode), .clrEn(clrEn), .statusRd(statusRd),
    .wakeReq(wakeReq), .backupClr(backupClr), .statusFlags(statusFlags)
  );

  // fields: code[15:13] en[12:11] clr[10] act[9:8] ticks[7:4] fireTick[3:0]
  localparam logic [15:0] VECS [6] = '{
    {3'd1, 2'b11, 1'b1, 2'b01, 4'd4,  4'd2},
    {3'd3, 2'b11, 1'b0, 2'b10, 4'd6,  4'd4},
    {3'd7, 2'b01, 1'b1, 2'b01, 4'd10, 4'd8},
    {3'd0, 2'b11, 1'b1, 2'b11, 4'd10, 4'd0},
    {3'd2, 2'b10, 1'b1, 2'b01, 4'd6,  4'd0},
    {3'd5, 2'b11, 1'b1, 2'b11, 4'd8,  4'd6}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one reference tick with the given active pins; returns after the edge
  task automatic doTick(input logic [1:0] act, input logic rd);
    @(negedge clk);
    pinN = ~act; refTick = 1'b1; statusRd = rd;
    @(negedge clk);
    refTick = 1'b0; statusRd = 1'b0;
  endtask

  task automatic readClear();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(wakeReq == 0 && backupClr == 0 && statusFlags == 0, "R11 reset",
          {wakeReq, backupClr, statusFlags}, 0);
    rstN = 1'b1;

    // table walk: R1, R2, R6, R8, R9
    for (int v = 0; v < 6; v++) begin
      logic [15:0] e;
      string req;
      int fireAt;
      e = VECS[v];
      fireAt = int'(e[3:0]);
      req = (e[15:13] == 0) ? "R1" : ((e[9:8] & ~e[12:11]) != 0) ? "R6" : "R2";
      @(negedge clk);
      dbcCode = e[15:13]; pinEn = e[12:11]; clrEn = e[10];
      doTick(2'b00, 1'b0);
      readClear();
      for (int t = 1; t <= int'(e[7:4]); t++) begin
        doTick(e[9:8], 1'b0);
        check(wakeReq == (t == fireAt), req, wakeReq, t == fireAt);
        check(backupClr == ((t == fireAt) && e[10]), "R8", backupClr,
              (t == fireAt) && e[10]);
      end
      check(statusFlags == ((fireAt != 0) ? (e[9:8] & e[12:11]) : 2'b00), "R9",
            statusFlags, (fireAt != 0) ? (e[9:8] & e[12:11]) : 0);
    end

    // R3: low level without ticks counts nothing
    dbcCode = 3'd1; pinEn = 2'b11; clrEn = 1'b0;
    doTick(2'b00, 1'b0);
    readClear();
    begin
      bit seen;
      seen = 0;
      @(negedge clk); pinN = 2'b10;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (wakeReq) seen = 1;
      end
      check(!seen, "R3 no tick", seen, 0);
    end
    doTick(2'b01, 1'b0);
    check(wakeReq == 0, "R3 first tick", wakeReq, 0);
    doTick(2'b01, 1'b0);
    check(wakeReq == 1, "R3 second tick", wakeReq, 1);
    @(negedge clk);
    check(wakeReq == 0, "R7 single pulse", wakeReq, 0);

    // R5: held low after firing, no repeat; re-arm after a high tick
    begin
      bit seen;
      seen = 0;
      for (int t = 0; t < 5; t++) begin
        doTick(2'b01, 1'b0);
        if (wakeReq) seen = 1;
      end
      check(!seen, "R5 no repeat", seen, 0);
    end
    doTick(2'b00, 1'b0);
    doTick(2'b01, 1'b0);
    doTick(2'b01, 1'b0);
    check(wakeReq == 1, "R5 re-arm", wakeReq, 1);

    // R9 sticky across idle, then R10 read clears
    repeat (10) @(negedge clk);
    check(statusFlags == 2'b01, "R9 sticky", statusFlags, 1);
    readClear();
    check(statusFlags == 2'b00, "R10 read clears", statusFlags, 0);

    // R4: a high tick restarts the count (code 2 = 3 ticks)
    dbcCode = 3'd2;
    doTick(2'b00, 1'b0);
    doTick(2'b10, 1'b0);
    doTick(2'b10, 1'b0);
    doTick(2'b00, 1'b0);
    doTick(2'b10, 1'b0);
    doTick(2'b10, 1'b0);
    check(wakeReq == 0, "R4 restart", wakeReq, 0);
    doTick(2'b10, 1'b0);
    check(wakeReq == 1, "R4 full window", wakeReq, 1);

    // R10: event on the read edge wins
    readClear();
    doTick(2'b00, 1'b0);
    doTick(2'b01, 1'b0);
    doTick(2'b01, 1'b0);
    doTick(2'b01, 1'b1);
    check(statusFlags == 2'b01, "R10 set wins", statusFlags, 1);

    summary();
    $finish;
  end
endmodule